// File: doc/BRIEF.md
# Descriptor Ring Doorbell Controller

This block sits between host software and a bus master engine that works through a circular ring of transaction descriptors kept in memory. Software fills one or more slots. It then publishes the index of the slot after the last one it filled in a head field of the control register, and sets a run bit. The controller keeps its own tail index. While the run bit is set and the tail differs from the head, it asks the engine to fetch the descriptor at `base + tail * 16`. When the engine reports that descriptor finished, the controller advances the tail. It carries on until the tail reaches the head.

Each finished descriptor can raise a completion flag, if the descriptor requested an interrupt, and an error flag, if the engine reports a failure. Software clears either flag by writing a one to its bit. Writing an all-zero word to the status register clears both flags at once, which is the initialisation write. A single interrupt line combines the completion flag with the error flag gated by an enable bit. The ring length is programmable through a size register that holds the number of entries minus one. Indices wrap after that last slot.

Top module: `doorbell_ctl`

## Requirements
- R1: After reset the status register reads 0, the control register reads 0, the size register reads RING_ENTRIES-1 (31), `fetch_req` is low and `irq` is low.
- R2: A fetch request presents `fetch_addr` = base + tail*16. The base is the 64-bit value whose low word is at offset 0x100 and high word at 0x104. `fetch_req` stays high with a stable address until `fetch_ack` is seen.
- R3: Each accepted completion (`done_valid` after the fetch was acknowledged) advances the tail, read in status bits 23:16, by one. After the index equal to the size register value, the tail wraps to 0. The tail changes at no other time.
- R4: Requests are issued only while the run bit (control bit 0) is set and tail differs from head (control bits 23:16). The block processes descriptors back to back until the tail equals the head, then goes idle.
- R5: Clearing the run bit while a descriptor is outstanding lets that descriptor finish and advance the tail, and no further request follows.
- R6: The completion flag (status bit 5) is set by a completion whose `done_irq` is high, and only by such a completion.
- R7: The error flag (status bit 4) is set by a completion whose `done_err` is high.
- R8: A status write with bit 5 or bit 4 set clears that flag only. A status write of all zeros clears both flags. A flag set and cleared in the same cycle ends up set.
- R9: `irq` is high exactly when the completion flag is set, or when the error flag is set and the error interrupt enable (control bit 4) is set.
- R10: Status bit 0 reads 1 from the cycle a descriptor is requested until the ring is drained or stopped.
- R11: The control register reads back head, error enable and run bit at their positions with all other bits 0. The size register keeps its low 8 bits and reads other bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| fetch_req | output | 1 | Request to fetch one descriptor |
| fetch_addr | output | 64 | Memory address of the requested descriptor |
| fetch_ack | input | 1 | Engine accepted the fetch request |
| done_valid | input | 1 | Engine finished the outstanding descriptor |
| done_irq | input | 1 | Finished descriptor asked for an interrupt |
| done_err | input | 1 | Finished descriptor ended in error |
| irq | output | 1 | Combined interrupt output |

## Verification
Three situations are hard to reach from the ports. The first is a wrap of the tail at a programmed ring length. The second is a stop that lands while a descriptor is outstanding. The third is the request for slot 0 that follows the wrap. The bench walks the tail forward through earlier scenarios until it sits on the last slot of a shortened ring. It then publishes a head just past index 0, so the next request after the wrap must point back to the base. For the stop case, the bench's engine model holds the acknowledge back while it rewrites the control register with the run bit cleared. The descriptor then finishes, and the bench watches the request line for several idle cycles.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;

    localparam int unsigned ADDR_W     = 12;
    localparam int unsigned DATA_W     = 32;
    localparam int unsigned IDX_W      = 8;
    localparam int unsigned BASE_W     = 64;
    localparam int unsigned DESC_SHIFT = 4;

    localparam logic [ADDR_W-1:0] OFF_BASE_LO = 12'h100;
    localparam logic [ADDR_W-1:0] OFF_BASE_HI = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_CTRL    = 12'h108;
    localparam logic [ADDR_W-1:0] OFF_STAT    = 12'h10C;
    localparam logic [ADDR_W-1:0] OFF_SIZE    = 12'h110;

    // bit positions software relies on
    localparam int unsigned B_RUN    = 0;
    localparam int unsigned B_ERR_IE = 4;
    localparam int unsigned B_BUSY   = 0;
    localparam int unsigned B_ERRF   = 4;
    localparam int unsigned B_COMPF  = 5;
    localparam int unsigned B_IDX_LO = 16;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] head;
        logic             err_ie;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic take;
        logic want_irq;
        logic failed;
    } done_t;

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] idx,
                                                  input logic [IDX_W-1:0] last);
        return (idx == last) ? '0 : idx + IDX_W'(1);
    endfunction

    function automatic logic [BASE_W-1:0] desc_addr(input logic [BASE_W-1:0] base,
                                                    input logic [IDX_W-1:0]  idx);
        return base + (BASE_W'(idx) << DESC_SHIFT);
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[B_IDX_LO +: IDX_W] = c.head;
        w[B_ERR_IE]          = c.err_ie;
        w[B_RUN]             = c.run;
        return w;
    endfunction

endpackage

// File: rtl/doorbell_regs.sv
module doorbell_regs
    import doorbell_pkg::*;
#(
    parameter int unsigned RING_ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [IDX_W-1:0]  tail,
    input  logic              busy,
    input  logic              comp_flag,
    input  logic              err_flag,
    output logic [DATA_W-1:0] rd_data,
    output logic [BASE_W-1:0] base,
    output ctrl_t             ctrl,
    output logic [IDX_W-1:0]  last_idx
);
    localparam logic [IDX_W-1:0] LAST_RST = IDX_W'(RING_ENTRIES - 1);
    localparam int unsigned HALF = BASE_W / 2;

    logic [DATA_W-1:0] stat_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            base     <= '0;
            ctrl     <= '0;
            last_idx <= LAST_RST;
        end else if (wr_en) begin
            unique case (wr_addr)
                OFF_BASE_LO: base[HALF-1:0]      <= wr_data;
                OFF_BASE_HI: base[BASE_W-1:HALF] <= wr_data;
                OFF_CTRL: begin
                    ctrl.head   <= wr_data[B_IDX_LO +: IDX_W];
                    ctrl.err_ie <= wr_data[B_ERR_IE];
                    ctrl.run    <= wr_data[B_RUN];
                end
                OFF_SIZE: last_idx <= wr_data[IDX_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        stat_word                     = '0;
        stat_word[B_IDX_LO +: IDX_W]  = tail;
        stat_word[B_COMPF]            = comp_flag;
        stat_word[B_ERRF]             = err_flag;
        stat_word[B_BUSY]             = busy;
    end

    always_comb begin
        unique case (rd_addr)
            OFF_BASE_LO: rd_data = base[HALF-1:0];
            OFF_BASE_HI: rd_data = base[BASE_W-1:HALF];
            OFF_CTRL:    rd_data = pack_ctrl(ctrl);
            OFF_STAT:    rd_data = stat_word;
            OFF_SIZE:    rd_data = DATA_W'(last_idx);
            default:     rd_data = '0;
        endcase
    end

endmodule

// File: rtl/doorbell_seq.sv
module doorbell_seq
    import doorbell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic [BASE_W-1:0] base,
    input  logic              fetch_ack,
    input  logic              done_valid,
    output logic              fetch_req,
    output logic [BASE_W-1:0] fetch_addr,
    output logic [IDX_W-1:0]  tail,
    output logic              busy,
    output logic              done_take
);
    seq_state_e       state;
    logic [IDX_W-1:0] tail_nx;

    assign tail_nx    = next_idx(tail, last_idx);
    assign done_take  = (state == SQ_WAIT) && done_valid;
    assign fetch_req  = (state == SQ_REQ);
    assign busy       = (state != SQ_IDLE);
    assign fetch_addr = desc_addr(base, tail);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            tail  <= '0;
        end else begin
            unique case (state)
                SQ_IDLE:
                    if (ctrl.run && (tail != ctrl.head)) state <= SQ_REQ;
                SQ_REQ:
                    if (fetch_ack) state <= SQ_WAIT;
                SQ_WAIT:
                    if (done_valid) begin
                        tail  <= tail_nx;
                        state <= (ctrl.run && (tail_nx != ctrl.head)) ? SQ_REQ : SQ_IDLE;
                    end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/doorbell_irq.sv
module doorbell_irq
    import doorbell_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  done_t             done,
    input  logic              err_ie,
    output logic              comp_flag,
    output logic              err_flag,
    output logic              irq
);
    logic init_clr, clr_comp, clr_err;

    assign init_clr = stat_wr && (wr_data == '0);
    assign clr_comp = init_clr || (stat_wr && wr_data[B_COMPF]);
    assign clr_err  = init_clr || (stat_wr && wr_data[B_ERRF]);

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_flag <= 1'b0;
            err_flag  <= 1'b0;
        end else begin
            if (done.take && done.want_irq) comp_flag <= 1'b1;
            else if (clr_comp)              comp_flag <= 1'b0;
            if (done.take && done.failed)   err_flag  <= 1'b1;
            else if (clr_err)               err_flag  <= 1'b0;
        end
    end

    assign irq = comp_flag || (err_flag && err_ie);

endmodule

// File: rtl/doorbell_ctl.sv
module doorbell_ctl
    import doorbell_pkg::*;
#(
    parameter int unsigned RING_ENTRIES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              fetch_req,
    output logic [BASE_W-1:0] fetch_addr,
    input  logic              fetch_ack,
    input  logic              done_valid,
    input  logic              done_irq,
    input  logic              done_err,
    output logic              irq
);
    logic [BASE_W-1:0] base;
    ctrl_t             ctrl;
    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  tail;
    logic              busy, done_take, comp_flag, err_flag, stat_wr;
    done_t             done;

    assign stat_wr = wr_en && (wr_addr == OFF_STAT);
    assign done    = '{take: done_take, want_irq: done_irq, failed: done_err};

    doorbell_regs #(.RING_ENTRIES(RING_ENTRIES)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .tail(tail), .busy(busy), .comp_flag(comp_flag),
        .err_flag(err_flag), .rd_data(rd_data), .base(base), .ctrl(ctrl),
        .last_idx(last_idx)
    );

    doorbell_seq u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .last_idx(last_idx), .base(base),
        .fetch_ack(fetch_ack), .done_valid(done_valid), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .tail(tail), .busy(busy), .done_take(done_take)
    );

    doorbell_irq u_irq (
        .clk(clk), .rst(rst), .stat_wr(stat_wr), .wr_data(wr_data), .done(done),
        .err_ie(ctrl.err_ie), .comp_flag(comp_flag), .err_flag(err_flag), .irq(irq)
    );

endmodule

// File: rtl/doorbell_chk.sv
module doorbell_chk
    import doorbell_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fetch_req,
    input logic              fetch_ack,
    input logic [BASE_W-1:0] fetch_addr,
    input logic [IDX_W-1:0]  tail,
    input logic              done_take,
    input logic              done_irq,
    input logic              done_err,
    input logic              run,
    input logic              stat_wr,
    input logic              comp_flag,
    input logic              err_flag
);
    // R2: request held with a stable address until acknowledged
    p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (fetch_req && !fetch_ack) |=> (fetch_req && $stable(fetch_addr)));

    // R3: tail moves only on an accepted completion
    p_tail_only_on_done_r3: assert property (@(posedge clk) disable iff (rst)
        !done_take |=> $stable(tail));

    // R4, R5: a new request starts only while the run bit was set
    p_req_needs_run_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(fetch_req) |-> $past(run));

    // R6: completion flag rises only from a completion that asked for it
    p_comp_cause_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(comp_flag) |-> $past(done_take && done_irq));

    // R7: error flag rises only from a failed completion
    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> $past(done_take && done_err));

    // R8: flags fall only after a status write
    p_comp_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(comp_flag) |-> $past(stat_wr));

endmodule

bind doorbell_ctl doorbell_chk u_chk (
    .clk(clk), .rst(rst), .fetch_req(fetch_req), .fetch_ack(fetch_ack),
    .fetch_addr(fetch_addr), .tail(tail), .done_take(done_take),
    .done_irq(done_irq), .done_err(done_err), .run(ctrl.run),
    .stat_wr(stat_wr), .comp_flag(comp_flag), .err_flag(err_flag)
);

// File: tb/sim_doorbell_ctl.sv
module sim_doorbell_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        fetch_req;
    logic [63:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic        done_valid = 1'b0;
    logic        done_irq = 1'b0;
    logic        done_err = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;

    always #10 clk = ~clk;   // 50 MHz

    doorbell_ctl u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_ack(fetch_ack), .done_valid(done_valid),
        .done_irq(done_irq), .done_err(done_err), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [7:0] head, input bit ie,
                                              input bit run);
        return {8'h00, head, 11'b0, ie, 3'b0, run};
    endfunction

    // wait for a request, check its address, acknowledge it
    task automatic take_req(input logic [63:0] exp_addr, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < 40 && !seen; i++) begin
            @(negedge clk);
            seen = fetch_req;
        end
        check(seen && fetch_addr == exp_addr, tag, seen ? fetch_addr : 64'h0, exp_addr);
        fetch_ack = 1'b1;
        @(negedge clk);
        fetch_ack = 1'b0;
    endtask

    task automatic finish_desc(input bit want_irq, input bit failed);
        @(negedge clk);
        done_valid = 1'b1; done_irq = want_irq; done_err = failed;
        @(negedge clk);
        done_valid = 1'b0; done_irq = 1'b0; done_err = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(12'h10C, d); check(d == 32'h0, "R1 status after reset", d, 0);
        rd(12'h108, d); check(d == 32'h0, "R1 control after reset", d, 0);
        rd(12'h110, d); check(d == 32'd31, "R1 size after reset", d, 31);
        check(!fetch_req && !irq, "R1 outputs idle", {fetch_req, irq}, 0);
    endtask

    task automatic t_single();
        logic [31:0] d;
        wr(12'h100, BASE[31:0]);
        wr(12'h104, BASE[63:32]);
        wr(12'h108, ctrl_word(8'd1, 1'b1, 1'b1));
        take_req(BASE, "R2 first descriptor address");
        finish_desc(1'b1, 1'b0);
        @(negedge clk);
        rd(12'h10C, d);
        check(d == 32'h0001_0020, "R3 R4 R6 tail=1, idle, completion flag", d, 32'h0001_0020);
        check(irq == 1'b1, "R9 irq from completion flag", irq, 1);
        wr(12'h10C, 32'h20);
        rd(12'h10C, d);
        check(d == 32'h0001_0000, "R8 completion flag cleared by write-one", d, 32'h0001_0000);
        check(irq == 1'b0, "R9 irq low after clear", irq, 0);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        wr(12'h108, ctrl_word(8'd4, 1'b1, 1'b1));
        for (int k = 1; k < 4; k++) begin
            take_req(BASE + 64'(k * 16), "R2 R4 back-to-back address");
            rd(12'h10C, d);
            check(d[0] == 1'b1, "R10 busy while outstanding", d[0], 1);
            finish_desc(1'b0, 1'b0);
        end
        repeat (3) @(negedge clk);
        rd(12'h10C, d);
        check(d == 32'h0004_0000, "R4 R6 drained at head, no flag without request bit", d,
              32'h0004_0000);
        check(!fetch_req, "R4 no request when tail equals head", fetch_req, 0);
    endtask

    task automatic t_error();
        logic [31:0] d;
        wr(12'h108, ctrl_word(8'd5, 1'b1, 1'b1));
        take_req(BASE + 64'd64, "R2 error descriptor address");
        finish_desc(1'b0, 1'b1);
        @(negedge clk);
        rd(12'h10C, d);
        check(d == 32'h0005_0010, "R7 error flag set", d, 32'h0005_0010);
        check(irq == 1'b1, "R9 irq from enabled error", irq, 1);
        wr(12'h108, ctrl_word(8'd5, 1'b0, 1'b1));
        check(irq == 1'b0, "R9 irq masked by error enable", irq, 0);
        wr(12'h10C, 32'h20);
        rd(12'h10C, d);
        check(d[4] == 1'b1, "R8 writing completion bit leaves error flag", d[4], 1);
        wr(12'h10C, 32'h0);
        rd(12'h10C, d);
        check(d == 32'h0005_0000, "R8 zero write clears all flags", d, 32'h0005_0000);
    endtask

    task automatic t_stop();
        logic [31:0] d;
        bit any = 1'b0;
        wr(12'h108, ctrl_word(8'd8, 1'b0, 1'b1));
        take_req(BASE + 64'd80, "R2 slot 5 address");
        finish_desc(1'b0, 1'b0);
        @(negedge clk);
        check(fetch_req && fetch_addr == BASE + 64'd96, "R4 next slot requested", fetch_addr,
              BASE + 64'd96);
        wr(12'h108, ctrl_word(8'd8, 1'b0, 1'b0));
        take_req(BASE + 64'd96, "R5 outstanding request kept");
        finish_desc(1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            any |= fetch_req;
        end
        check(!any, "R5 no request after run cleared", any, 0);
        rd(12'h10C, d);
        check(d == 32'h0007_0000, "R5 tail advanced once and idle", d, 32'h0007_0000);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        wr(12'h110, 32'hFFFF_FF07);
        rd(12'h110, d);
        check(d == 32'h7, "R11 size keeps low byte", d, 7);
        wr(12'h108, 32'hFFFF_FFFF & ctrl_word(8'd1, 1'b1, 1'b1) | 32'hFF00_0000);
        rd(12'h108, d);
        check(d == 32'h0001_0011, "R11 control readback masks unused bits", d, 32'h0001_0011);
        take_req(BASE + 64'd112, "R2 last slot of short ring");
        finish_desc(1'b0, 1'b0);
        take_req(BASE, "R3 wrap returns to slot 0");
        finish_desc(1'b0, 1'b0);
        @(negedge clk);
        rd(12'h10C, d);
        check(d == 32'h0001_0000, "R3 tail wrapped to 1", d, 32'h0001_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_error();
        t_stop();
        t_wrap();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule